// File: doc/BRIEF.md
# Dual-Interface Block Access Rights Checker

This block guards one shared nonvolatile store that two requesters reach independently: a contactless front end and a processor on the contact side. The store is organised as sectors of fixed-size blocks. A requester always names a sector, a block inside it and a direction, and always moves a whole block. Byte addressing does not exist on either side.

Each block carries two separate 2-bit rights codes, one for each interface. These codes live in a small rights register file that the contact side programs one protection word at a time. Every accepted request is checked against the code that belongs to its own interface. The request is then either performed, which gives a one-cycle done pulse (plus the block data for a read), or refused, which gives a one-cycle error pulse and leaves the store untouched.

Only one interface is active at any time. When the block is idle it chooses which requester to serve. A requester that has just been served keeps priority. The other side takes over only when the active side has no valid request, and the change takes effect only between transactions. The active side is reported on a status flag.

Top module: `dacc_access_guard`

## Requirements
- R1: After reset the mode flag is 0 (contactless active), no done or error pulse is present, and every rights code of both interfaces reads as no access, so that any request is refused.
- R2: Rights codes decode as 00 = no access, 01 = no access, 10 = read only, 11 = read and write. A refused read or write gives an error pulse.
- R3: The global block index is sector × blocks-per-sector + block. Protection word w, field k (bits 2k+1:2k of the 16-bit word) holds the code of global block 8w+k.
- R4: The two interfaces have fully separate rights tables. A code written for one interface never changes the decision for the other.
- R5: A refused request raises err for exactly one cycle, with done low, and does not alter the stored block.
- R6: An accepted request is answered in the second cycle after the accepting edge. A granted request gives done for exactly one cycle, and a granted read returns the whole block on rdata.
- R7: Only one request is in progress at a time. In the cycle after an acceptance both ready outputs are low, and at no time are both ready outputs high together.
- R8: The mode flag (1 = contact side active) takes the value of the side whose request was accepted, at the accepting edge. It holds its value in every cycle with no acceptance.
- R9: When both sides present valid while idle, the currently active side is served. The inactive side receives no ready and is served only once the active side stops requesting.
- R10: rdata of each side is all zeros except in the cycle of a granted read done pulse for that side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cl_valid | input | 1 | Contactless request valid |
| cl_ready | output | 1 | Contactless request accepted this cycle |
| cl_sector | input | SEC_W | Contactless sector index |
| cl_block | input | BLK_W | Contactless block index inside the sector |
| cl_write | input | 1 | Contactless direction, 1 = write |
| cl_wdata | input | BLOCK_BITS | Contactless write block |
| cl_done | output | 1 | Contactless grant pulse |
| cl_err | output | 1 | Contactless refusal pulse |
| cl_rdata | output | BLOCK_BITS | Contactless read block |
| ct_valid | input | 1 | Contact-side request valid |
| ct_ready | output | 1 | Contact-side request accepted this cycle |
| ct_sector | input | SEC_W | Contact-side sector index |
| ct_block | input | BLK_W | Contact-side block index inside the sector |
| ct_write | input | 1 | Contact-side direction, 1 = write |
| ct_wdata | input | BLOCK_BITS | Contact-side write block |
| ct_done | output | 1 | Contact-side grant pulse |
| ct_err | output | 1 | Contact-side refusal pulse |
| ct_rdata | output | BLOCK_BITS | Contact-side read block |
| cfg_we | input | 1 | Rights word write strobe |
| cfg_side | input | 1 | Table selected, 0 = contactless, 1 = contact |
| cfg_word | input | WORD_W | Protection word index |
| cfg_data | input | 16 | Eight 2-bit rights fields |
| mode_ct | output | 1 | Active interface flag, 1 = contact side |

## Verification
The assertions assume that a requester keeps its valid and its request fields steady until it sees ready. They also assume that rights words are not rewritten in the cycle in which a request is being judged. The directed tasks keep to both rules: they change stimulus only on falling edges, release valid right after the accepting edge, and program rights only while no request is open. Arbitration is tested by raising both valids in the same cycle with the mode flag set either way.

// File: rtl/dacc_pkg.sv
package dacc_pkg;
   localparam int FIELDS_PER_WORD = 8;
   localparam int RIGHTS_W        = 2;
   localparam int CFG_BITS        = FIELDS_PER_WORD * RIGHTS_W;

   typedef enum logic [1:0] {
      RC_DENY_A = 2'b00,
      RC_DENY_B = 2'b01,
      RC_READ   = 2'b10,
      RC_FULL   = 2'b11
   } rights_e;

   typedef enum logic {
      SIDE_CL = 1'b0,
      SIDE_CT = 1'b1
   } side_e;

   // true when the code permits the requested direction
   function automatic logic rights_allow(input logic [1:0] code, input logic is_write);
      if (is_write) rights_allow = (code == RC_FULL);
      else          rights_allow = (code == RC_READ) || (code == RC_FULL);
   endfunction
endpackage

// File: rtl/dacc_rights_file.sv
module dacc_rights_file
   import dacc_pkg::*;
#(
   parameter int NUM_BLOCKS = 16,
   parameter int IDX_W      = 4,
   parameter int WORD_W     = 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cfg_we,
   input  logic                  cfg_side,
   input  logic [WORD_W-1:0]     cfg_word,
   input  logic [CFG_BITS-1:0]   cfg_data,
   input  logic                  look_side,
   input  logic [IDX_W-1:0]      look_idx,
   output logic [RIGHTS_W-1:0]   look_code
);
   localparam int NUM_SIDES = 2;

   logic [RIGHTS_W-1:0] codes [NUM_SIDES][NUM_BLOCKS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < NUM_SIDES; s++) begin
            for (int b = 0; b < NUM_BLOCKS; b++) begin
               codes[s][b] <= RC_DENY_A;
            end
         end
      end else if (cfg_we) begin
         for (int b = 0; b < NUM_BLOCKS; b++) begin
            if ((b / FIELDS_PER_WORD) == int'(cfg_word)) begin
               codes[cfg_side][b] <= cfg_data[(b % FIELDS_PER_WORD)*RIGHTS_W +: RIGHTS_W];
            end
         end
      end
   end

   assign look_code = codes[look_side][look_idx];
endmodule

// File: rtl/dacc_arbiter.sv
module dacc_arbiter (
   input  logic clk,
   input  logic rst_n,
   input  logic cl_valid,
   input  logic ct_valid,
   input  logic idle,
   output logic pick_any,
   output logic pick_ct,
   output logic mode_ct
);
   // the side that was served last keeps priority
   always_comb begin
      pick_any = idle && (cl_valid || ct_valid);
      if (mode_ct) pick_ct = ct_valid;
      else         pick_ct = ct_valid && !cl_valid;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        mode_ct <= 1'b0;
      else if (pick_any) mode_ct <= pick_ct;
   end
endmodule

// File: rtl/dacc_block_store.sv
module dacc_block_store #(
   parameter int NUM_BLOCKS     = 16,
   parameter int IDX_W          = 4,
   parameter int BLOCK_BITS     = 32,
   parameter bit CLEAR_ON_RESET = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [IDX_W-1:0]      wr_idx,
   input  logic [BLOCK_BITS-1:0] wr_data,
   input  logic [IDX_W-1:0]      rd_idx,
   output logic [BLOCK_BITS-1:0] rd_data
);
   logic [BLOCK_BITS-1:0] mem [NUM_BLOCKS];

   generate
      if (CLEAR_ON_RESET) begin : g_clear
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < NUM_BLOCKS; i++) mem[i] <= '0;
            end else if (wr_en) begin
               mem[wr_idx] <= wr_data;
            end
         end
      end else begin : g_keep
         logic rst_seen;
         always_ff @(posedge clk) begin
            rst_seen <= rst_n;
            if (wr_en) mem[wr_idx] <= wr_data;
         end
      end
   endgenerate

   assign rd_data = mem[rd_idx];
endmodule

// File: rtl/dacc_access_guard.sv
module dacc_access_guard
   import dacc_pkg::*;
#(
   parameter int NUM_SECTORS     = 4,
   parameter int BLKS_PER_SECTOR = 4,
   parameter int BLOCK_BITS      = 32,
   parameter bit CLEAR_ON_RESET  = 1'b1,
   localparam int SEC_W      = $clog2(NUM_SECTORS),
   localparam int BLK_W      = $clog2(BLKS_PER_SECTOR),
   localparam int NUM_BLOCKS = NUM_SECTORS * BLKS_PER_SECTOR,
   localparam int IDX_W      = SEC_W + BLK_W,
   localparam int NUM_WORDS  = NUM_BLOCKS / FIELDS_PER_WORD,
   localparam int WORD_W     = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cl_valid,
   output logic                  cl_ready,
   input  logic [SEC_W-1:0]      cl_sector,
   input  logic [BLK_W-1:0]      cl_block,
   input  logic                  cl_write,
   input  logic [BLOCK_BITS-1:0] cl_wdata,
   output logic                  cl_done,
   output logic                  cl_err,
   output logic [BLOCK_BITS-1:0] cl_rdata,
   input  logic                  ct_valid,
   output logic                  ct_ready,
   input  logic [SEC_W-1:0]      ct_sector,
   input  logic [BLK_W-1:0]      ct_block,
   input  logic                  ct_write,
   input  logic [BLOCK_BITS-1:0] ct_wdata,
   output logic                  ct_done,
   output logic                  ct_err,
   output logic [BLOCK_BITS-1:0] ct_rdata,
   input  logic                  cfg_we,
   input  logic                  cfg_side,
   input  logic [WORD_W-1:0]     cfg_word,
   input  logic [CFG_BITS-1:0]   cfg_data,
   output logic                  mode_ct
);
   // elaboration-time parameter checks
   if (NUM_SECTORS < 2 || (NUM_SECTORS & (NUM_SECTORS - 1)) != 0) begin : g_bad_sectors
      $error("NUM_SECTORS must be a power of two of at least 2");
   end
   if (BLKS_PER_SECTOR < 2 || (BLKS_PER_SECTOR & (BLKS_PER_SECTOR - 1)) != 0) begin : g_bad_blocks
      $error("BLKS_PER_SECTOR must be a power of two of at least 2");
   end
   if (NUM_BLOCKS % FIELDS_PER_WORD != 0) begin : g_bad_words
      $error("total block count must fill whole protection words");
   end
   if (BLOCK_BITS < 8) begin : g_bad_width
      $error("BLOCK_BITS must be at least 8");
   end

   // request register for the single transaction in progress
   typedef struct packed {
      logic                  side;
      logic                  write;
      logic [IDX_W-1:0]      idx;
      logic [BLOCK_BITS-1:0] wdata;
   } req_t;

   logic busy;
   req_t req_q;
   logic pick_any, pick_ct;
   logic [RIGHTS_W-1:0] code;
   logic grant;
   logic [BLOCK_BITS-1:0] blk_rd;

   dacc_arbiter u_arb (
      .clk      (clk),
      .rst_n    (rst_n),
      .cl_valid (cl_valid),
      .ct_valid (ct_valid),
      .idle     (!busy),
      .pick_any (pick_any),
      .pick_ct  (pick_ct),
      .mode_ct  (mode_ct)
   );

   assign cl_ready = pick_any && !pick_ct;
   assign ct_ready = pick_any &&  pick_ct;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         req_q <= '0;
      end else begin
         busy <= pick_any;
         if (pick_any) begin
            if (pick_ct) begin
               req_q.side  <= SIDE_CT;
               req_q.write <= ct_write;
               req_q.idx   <= {ct_sector, ct_block};
               req_q.wdata <= ct_wdata;
            end else begin
               req_q.side  <= SIDE_CL;
               req_q.write <= cl_write;
               req_q.idx   <= {cl_sector, cl_block};
               req_q.wdata <= cl_wdata;
            end
         end
      end
   end

   dacc_rights_file #(
      .NUM_BLOCKS (NUM_BLOCKS),
      .IDX_W      (IDX_W),
      .WORD_W     (WORD_W)
   ) u_rights (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_side  (cfg_side),
      .cfg_word  (cfg_word),
      .cfg_data  (cfg_data),
      .look_side (req_q.side),
      .look_idx  (req_q.idx),
      .look_code (code)
   );

   assign grant = busy && rights_allow(code, req_q.write);

   dacc_block_store #(
      .NUM_BLOCKS     (NUM_BLOCKS),
      .IDX_W          (IDX_W),
      .BLOCK_BITS     (BLOCK_BITS),
      .CLEAR_ON_RESET (CLEAR_ON_RESET)
   ) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (grant && req_q.write),
      .wr_idx  (req_q.idx),
      .wr_data (req_q.wdata),
      .rd_idx  (req_q.idx),
      .rd_data (blk_rd)
   );

   // response registers, one pulse per finished transaction
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cl_done  <= 1'b0;
         cl_err   <= 1'b0;
         cl_rdata <= '0;
         ct_done  <= 1'b0;
         ct_err   <= 1'b0;
         ct_rdata <= '0;
      end else begin
         cl_done  <= grant && (req_q.side == SIDE_CL);
         cl_err   <= busy && !grant && (req_q.side == SIDE_CL);
         cl_rdata <= (grant && (req_q.side == SIDE_CL) && !req_q.write) ? blk_rd : '0;
         ct_done  <= grant && (req_q.side == SIDE_CT);
         ct_err   <= busy && !grant && (req_q.side == SIDE_CT);
         ct_rdata <= (grant && (req_q.side == SIDE_CT) && !req_q.write) ? blk_rd : '0;
      end
   end
endmodule

// File: rtl/dacc_access_guard_chk.sv
module dacc_access_guard_chk #(
   parameter int BLOCK_BITS = 32
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  cl_valid,
   input logic                  cl_ready,
   input logic                  cl_done,
   input logic                  cl_err,
   input logic [BLOCK_BITS-1:0] cl_rdata,
   input logic                  ct_valid,
   input logic                  ct_ready,
   input logic                  ct_done,
   input logic                  ct_err,
   input logic [BLOCK_BITS-1:0] ct_rdata,
   input logic                  mode_ct
);
   logic acc;
   assign acc = (cl_valid && cl_ready) || (ct_valid && ct_ready);

   a_r7_one_ready: assert property (@(posedge clk) disable iff (!rst_n)
      !(cl_ready && ct_ready));
   a_r7_quiet_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
      acc |=> (!cl_ready && !ct_ready));
   a_r6_cl_answer: assert property (@(posedge clk) disable iff (!rst_n)
      (cl_valid && cl_ready) |-> ##2 (cl_done != cl_err));
   a_r6_ct_answer: assert property (@(posedge clk) disable iff (!rst_n)
      (ct_valid && ct_ready) |-> ##2 (ct_done != ct_err));
   a_r5_cl_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(cl_done && cl_err));
   a_r5_ct_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(ct_done && ct_err));
   a_r5_cl_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      cl_err |=> !cl_err);
   a_r6_ct_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      ct_done |=> !ct_done);
   a_r8_to_ct: assert property (@(posedge clk) disable iff (!rst_n)
      (ct_valid && ct_ready) |=> mode_ct);
   a_r8_to_cl: assert property (@(posedge clk) disable iff (!rst_n)
      (cl_valid && cl_ready) |=> !mode_ct);
   a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !acc |=> $stable(mode_ct));
   a_r9_keep_cl: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_ct && cl_valid && (cl_ready || ct_ready)) |-> cl_ready);
   a_r9_keep_ct: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_ct && ct_valid && (cl_ready || ct_ready)) |-> ct_ready);
   a_r10_cl_idle_data: assert property (@(posedge clk) disable iff (!rst_n)
      !cl_done |-> (cl_rdata == '0));
   a_r10_ct_idle_data: assert property (@(posedge clk) disable iff (!rst_n)
      !ct_done |-> (ct_rdata == '0));
endmodule

bind dacc_access_guard dacc_access_guard_chk #(.BLOCK_BITS(BLOCK_BITS)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cl_valid (cl_valid),
   .cl_ready (cl_ready),
   .cl_done  (cl_done),
   .cl_err   (cl_err),
   .cl_rdata (cl_rdata),
   .ct_valid (ct_valid),
   .ct_ready (ct_ready),
   .ct_done  (ct_done),
   .ct_err   (ct_err),
   .ct_rdata (ct_rdata),
   .mode_ct  (mode_ct)
);

// File: tb/dacc_access_guard_bench.sv
`timescale 1ns/1ps
module dacc_access_guard_bench;
   localparam int SEC_W = 2;
   localparam int BLK_W = 2;
   localparam int BB    = 32;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic rst_n;
   logic cl_valid, cl_ready, cl_write, cl_done, cl_err;
   logic [SEC_W-1:0] cl_sector;
   logic [BLK_W-1:0] cl_block;
   logic [BB-1:0] cl_wdata, cl_rdata;
   logic ct_valid, ct_ready, ct_write, ct_done, ct_err;
   logic [SEC_W-1:0] ct_sector;
   logic [BLK_W-1:0] ct_block;
   logic [BB-1:0] ct_wdata, ct_rdata;
   logic cfg_we, cfg_side;
   logic [0:0] cfg_word;
   logic [15:0] cfg_data;
   logic mode_ct;

   dacc_access_guard u_dacc_access_guard (
      .clk(clk), .rst_n(rst_n),
      .cl_valid(cl_valid), .cl_ready(cl_ready), .cl_sector(cl_sector), .cl_block(cl_block),
      .cl_write(cl_write), .cl_wdata(cl_wdata), .cl_done(cl_done), .cl_err(cl_err), .cl_rdata(cl_rdata),
      .ct_valid(ct_valid), .ct_ready(ct_ready), .ct_sector(ct_sector), .ct_block(ct_block),
      .ct_write(ct_write), .ct_wdata(ct_wdata), .ct_done(ct_done), .ct_err(ct_err), .ct_rdata(ct_rdata),
      .cfg_we(cfg_we), .cfg_side(cfg_side), .cfg_word(cfg_word), .cfg_data(cfg_data),
      .mode_ct(mode_ct)
   );

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   task automatic check_eq(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic cfg_put(input bit side, input bit word, input logic [15:0] data);
      @(negedge clk);
      cfg_we = 1'b1; cfg_side = side; cfg_word = word; cfg_data = data;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic drive(input bit side, input int sec, input int blk, input bit wr, input logic [BB-1:0] wd);
      if (side) begin
         ct_valid = 1'b1; ct_sector = sec[SEC_W-1:0]; ct_block = blk[BLK_W-1:0];
         ct_write = wr; ct_wdata = wd;
      end else begin
         cl_valid = 1'b1; cl_sector = sec[SEC_W-1:0]; cl_block = blk[BLK_W-1:0];
         cl_write = wr; cl_wdata = wd;
      end
   endtask

   // one complete request with its full response check
   task automatic do_req(input string req, input bit side, input int sec, input int blk, input bit wr,
                         input logic [BB-1:0] wd, input bit exp_ok, input logic [BB-1:0] exp_rd);
      bit rdy;
      int guard;
      @(negedge clk);
      drive(side, sec, blk, wr, wd);
      #1;
      guard = 0;
      rdy = side ? ct_ready : cl_ready;
      while (!rdy && guard < 50) begin
         @(negedge clk); #1; guard++;
         rdy = side ? ct_ready : cl_ready;
      end
      check_eq(req, "ready", {63'd0, rdy}, 64'd1);
      @(posedge clk);
      @(negedge clk);
      cl_valid = 1'b0; ct_valid = 1'b0;
      // R7: busy cycle, nothing accepted, no answer yet
      check_eq("R7", "ready during busy", {62'd0, cl_ready, ct_ready}, 64'd0);
      check_eq("R6", "early answer", {60'd0, cl_done, cl_err, ct_done, ct_err}, 64'd0);
      @(negedge clk);
      if (side) begin
         check_eq(req, "done", {63'd0, ct_done}, {63'd0, exp_ok});
         check_eq(req, "err",  {63'd0, ct_err},  {63'd0, !exp_ok});
         check_eq("R10", "rdata", {32'd0, ct_rdata}, {32'd0, (exp_ok && !wr) ? exp_rd : 32'd0});
      end else begin
         check_eq(req, "done", {63'd0, cl_done}, {63'd0, exp_ok});
         check_eq(req, "err",  {63'd0, cl_err},  {63'd0, !exp_ok});
         check_eq("R10", "rdata", {32'd0, cl_rdata}, {32'd0, (exp_ok && !wr) ? exp_rd : 32'd0});
      end
      check_eq("R8", "mode flag", {63'd0, mode_ct}, {63'd0, side});
      @(negedge clk);
      check_eq("R5", "pulse width", {60'd0, cl_done, cl_err, ct_done, ct_err}, 64'd0);
   endtask

   task automatic t_reset;
      check_eq("R1", "mode after reset", {63'd0, mode_ct}, 64'd0);
      check_eq("R1", "pulses after reset", {60'd0, cl_done, cl_err, ct_done, ct_err}, 64'd0);
      check_eq("R1", "ready without valid", {62'd0, cl_ready, ct_ready}, 64'd0);
      do_req("R1", 1'b0, 0, 0, 1'b0, '0, 1'b0, '0);
      do_req("R1", 1'b1, 0, 0, 1'b1, 32'h1111_1111, 1'b0, '0);
      do_req("R1", 1'b1, 3, 3, 1'b0, '0, 1'b0, '0);
   endtask

   task automatic t_decode;
      // contactless word 0: blk0=00 blk1=01 blk2=10 blk3=11
      cfg_put(1'b0, 1'b0, 16'h00E4);
      cfg_put(1'b1, 1'b0, 16'hFFFF);
      for (int k = 0; k < 4; k++) do_req("R6", 1'b1, 0, k, 1'b1, 32'hA0A0_0000 + k, 1'b1, '0);
      do_req("R2", 1'b0, 0, 0, 1'b0, '0, 1'b0, '0);
      do_req("R2", 1'b0, 0, 1, 1'b0, '0, 1'b0, '0);
      do_req("R2", 1'b0, 0, 2, 1'b0, '0, 1'b1, 32'hA0A0_0002);
      do_req("R2", 1'b0, 0, 2, 1'b1, 32'hFFFF_FFFF, 1'b0, '0);
      do_req("R5", 1'b0, 0, 2, 1'b0, '0, 1'b1, 32'hA0A0_0002);
      do_req("R2", 1'b0, 0, 3, 1'b1, 32'h5A5A_1234, 1'b1, '0);
      do_req("R6", 1'b1, 0, 3, 1'b0, '0, 1'b1, 32'h5A5A_1234);
      do_req("R4", 1'b1, 0, 0, 1'b0, '0, 1'b1, 32'hA0A0_0000);
   endtask

   task automatic t_sector_map;
      // word 1 field 5 = global block 13 = sector 3 block 1
      cfg_put(1'b0, 1'b1, 16'h0C00);
      do_req("R3", 1'b0, 3, 1, 1'b1, 32'hC0DE_0013, 1'b1, '0);
      do_req("R3", 1'b0, 3, 0, 1'b1, 32'hDEAD_0012, 1'b0, '0);
      do_req("R3", 1'b0, 3, 1, 1'b0, '0, 1'b1, 32'hC0DE_0013);
      do_req("R4", 1'b1, 3, 1, 1'b0, '0, 1'b0, '0);
      cfg_put(1'b1, 1'b1, 16'h0800);
      do_req("R2", 1'b1, 3, 1, 1'b0, '0, 1'b1, 32'hC0DE_0013);
      do_req("R5", 1'b1, 3, 1, 1'b1, 32'h0BAD_0BAD, 1'b0, '0);
      do_req("R5", 1'b0, 3, 1, 1'b0, '0, 1'b1, 32'hC0DE_0013);
   endtask

   task automatic t_arbitrate;
      do_req("R8", 1'b0, 0, 2, 1'b0, '0, 1'b1, 32'hA0A0_0002);
      @(negedge clk);
      drive(1'b0, 0, 2, 1'b0, '0);
      drive(1'b1, 0, 1, 1'b0, '0);
      #1;
      check_eq("R9", "active side wins", {62'd0, cl_ready, ct_ready}, 64'd2);
      @(negedge clk);
      cl_valid = 1'b0;
      check_eq("R9", "waiting side held", {63'd0, ct_ready}, 64'd0);
      @(negedge clk);
      check_eq("R9", "first answer", {63'd0, cl_done}, 64'd1);
      check_eq("R9", "switch ready", {63'd0, ct_ready}, 64'd1);
      @(negedge clk);
      ct_valid = 1'b0;
      check_eq("R8", "mode switched", {63'd0, mode_ct}, 64'd1);
      @(negedge clk);
      check_eq("R9", "second answer", {32'd0, ct_rdata}, {32'd0, 32'hA0A0_0001});
      // contact side active now: both valid, contact wins
      @(negedge clk);
      drive(1'b0, 0, 2, 1'b0, '0);
      drive(1'b1, 0, 3, 1'b0, '0);
      #1;
      check_eq("R9", "sticky contact", {62'd0, cl_ready, ct_ready}, 64'd1);
      @(negedge clk);
      ct_valid = 1'b0;
      @(negedge clk);
      check_eq("R9", "contact answer", {32'd0, ct_rdata}, {32'd0, 32'h5A5A_1234});
      check_eq("R9", "contactless waits", {63'd0, cl_ready}, 64'd1);
      @(negedge clk);
      cl_valid = 1'b0;
      check_eq("R8", "back to contactless", {63'd0, mode_ct}, 64'd0);
      @(negedge clk);
      check_eq("R9", "contactless answer", {32'd0, cl_rdata}, {32'd0, 32'hA0A0_0002});
   endtask

   task automatic summary;
      if (!finished) begin
         finished = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      rst_n = 1'b0;
      cl_valid = 1'b0; cl_sector = '0; cl_block = '0; cl_write = 1'b0; cl_wdata = '0;
      ct_valid = 1'b0; ct_sector = '0; ct_block = '0; ct_write = 1'b0; ct_wdata = '0;
      cfg_we = 1'b0; cfg_side = 1'b0; cfg_word = '0; cfg_data = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_decode();
      t_sector_map();
      t_arbitrate();
      repeat (2) @(negedge clk);
      summary();
   end
endmodule